// File: doc/BRIEF.md
# Pulse-Width Coded Single-Line Bit Receiver

This block turns one asynchronous, idle-low input line into a stream of decoded bits. Each bit arrives as a high pulse whose duration carries its value. A short pulse means 0 and a long pulse means 1. Pulses whose width falls in the band between the two are rejected. The line is first brought into the system clock domain and cleaned of narrow spikes. The receiver then times every high level and every low level in clock cycles.

The decision for a pulse is made only when the pulse ends. On that falling edge the block raises a one-cycle bit strobe with the value, or a one-cycle bad-width flag. The same falling edge always produces a separate one-cycle strobe, which a read-back shifter can use as its shift clock.

A pulse that starts before the minimum low gap has elapsed is discarded and reported through a gap-error strobe. Every threshold is a parameter counted in system clock cycles. Framing of the bits into words is left to the consumer.

Top module: `pw_bit_rx`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, all strobe outputs are low. Reset also clears the level timer, so a pulse whose rising edge follows the release of reset by fewer than MIN_GAP_W low cycles is treated as a gap violation.
- R2: A high pulse lasting from MIN_ZERO_W up to MAX_ZERO_W cycles, inclusive, yields exactly one `bit_vld_o` strobe with `bit_val_o` = 0.
- R3: A high pulse of MIN_ONE_W cycles or more yields exactly one `bit_vld_o` strobe with `bit_val_o` = 1. This holds for any length, because the timer saturates and never wraps.
- R4: A high pulse shorter than MIN_ZERO_W cycles but still passing the spike filter yields one `bad_width_o` strobe and no bit. The same applies to a pulse of more than MAX_ZERO_W and fewer than MIN_ONE_W cycles. At most one of `bit_vld_o`, `bad_width_o` and `gap_err_o` is high in any cycle.
- R5: A high spike one clock wide produces no strobe of any kind.
- R6: A rising edge that follows fewer than MIN_GAP_W low cycles raises `gap_err_o` for one cycle, and that pulse yields no bit and no bad-width flag. A low gap of exactly MIN_GAP_W cycles is accepted.
- R7: Every falling edge of the filtered line, including the end of a discarded pulse, produces one `fall_stb_o` strobe. `bit_vld_o` and `bad_width_o` are only ever high together with `fall_stb_o`.
- R8: A line held high across and after reset never produces a bit strobe.
- R9: No bit strobe is issued while the pulse is still high, even after MIN_ONE_W cycles have passed.
- R10: `bit_vld_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Asynchronous pulse-coded line, idle low |
| bit_vld_o | output | 1 | One-cycle strobe: a bit was decoded |
| bit_val_o | output | 1 | Decoded bit value, valid with `bit_vld_o` |
| fall_stb_o | output | 1 | One-cycle strobe on each falling edge of the filtered line |
| bad_width_o | output | 1 | One-cycle strobe: the pulse width was outside both bit bands |
| gap_err_o | output | 1 | One-cycle strobe: a pulse began before the minimum gap had elapsed |

## Verification
Pulses are driven at each edge of the two bit bands: the shortest and longest zero, one cycle past the zero band, one cycle short of a one, and the exact one threshold. This separates off-by-one errors in each of the three comparisons. A two-cycle pulse and a one-cycle spike separate the width check from the spike filter. Low gaps of exactly the minimum and one cycle less check the gap comparison. Pulses started straight after reset, and a line stuck high through reset, show that the cleared timer and the edge detector keep a floating line from producing bits. A very long pulse, sampled while still high, shows that the decision waits for the falling edge.

// File: rtl/pwrx_pkg.sv
package pwrx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,   // line low, gap being timed
        RX_HIGH = 2'd1,   // accepted pulse in progress
        RX_DROP = 2'd2    // pulse discarded after gap violation
    } rx_state_e;

    typedef enum logic [1:0] {
        PW_ZERO = 2'd0,
        PW_ONE  = 2'd1,
        PW_BAD  = 2'd2
    } pw_class_e;

    typedef struct packed {
        logic bit_vld;
        logic bit_val;
        logic fall;
        logic bad;
        logic gap_err;
    } rx_evt_s;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic pw_class_e classify(input int unsigned width,
                                           input int unsigned zero_lo,
                                           input int unsigned zero_hi,
                                           input int unsigned one_lo);
        if (width >= one_lo)
            return PW_ONE;
        if (width >= zero_lo && width <= zero_hi)
            return PW_ZERO;
        return PW_BAD;
    endfunction

endpackage

// File: rtl/pw_line_filter.sv
module pw_line_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned VOTE_TAPS   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic lvl_o
);
    localparam int unsigned VOTE_NEED = VOTE_TAPS / 2 + 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE_TAPS-1:1]   hist_q;
    logic [VOTE_TAPS-1:0]   window;
    logic                   vote;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
    end

    // history of the synchronized level, newest tap is the sync output itself
    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q[1] <= sync_q[SYNC_STAGES-1];
    end

    generate
        for (genvar t = 2; t < VOTE_TAPS; t++) begin : g_hist
            always_ff @(posedge clk) begin
                if (rst) hist_q[t] <= 1'b0;
                else     hist_q[t] <= hist_q[t-1];
            end
        end
    endgenerate

    assign window = {hist_q, sync_q[SYNC_STAGES-1]};

    always_comb begin
        vote = ($countones(window) >= VOTE_NEED);
    end

    always_ff @(posedge clk) begin
        if (rst) lvl_o <= 1'b0;
        else     lvl_o <= vote;
    end

endmodule

// File: rtl/pw_span_counter.sv
module pw_span_counter #(
    parameter int unsigned SAT   = 64,
    parameter int unsigned CNT_W = $clog2(SAT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] SAT_C = CNT_W'(SAT);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_o <= '0;
        else if (restart_i)
            cnt_o <= CNT_W'(1);
        else if (cnt_o != SAT_C)
            cnt_o <= cnt_o + CNT_W'(1);
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        cnt_o <= SAT_C);  // R3

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!restart_i && cnt_o == SAT_C) |=> (cnt_o == SAT_C));  // R3

endmodule

// File: rtl/pw_decide.sv
module pw_decide
    import pwrx_pkg::*;
#(
    parameter int unsigned MIN_ZERO_W = 5,
    parameter int unsigned MAX_ZERO_W = 1000,
    parameter int unsigned MIN_ONE_W  = 5000,
    parameter int unsigned MIN_GAP_W  = 1000,
    parameter int unsigned CNT_W      = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lvl_i,
    input  logic [CNT_W-1:0] span_i,
    output logic             restart_o,
    output rx_evt_s          evt_o
);
    localparam logic [CNT_W-1:0] GAP_C = CNT_W'(MIN_GAP_W);

    rx_state_e state_q, state_d;
    logic      lvl_q;
    logic      rise, fall;
    pw_class_e cls;
    rx_evt_s   evt_d;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl_i;
    end

    assign rise      = lvl_i & ~lvl_q;
    assign fall      = ~lvl_i & lvl_q;
    assign restart_o = rise | fall;

    always_comb begin
        cls = classify(32'(span_i), MIN_ZERO_W, MAX_ZERO_W, MIN_ONE_W);
    end

    always_comb begin
        state_d = state_q;
        evt_d   = '0;
        case (state_q)
            RX_IDLE: begin
                if (rise) begin
                    if (span_i >= GAP_C) begin
                        state_d = RX_HIGH;
                    end else begin
                        state_d       = RX_DROP;
                        evt_d.gap_err = 1'b1;
                    end
                end
            end
            RX_HIGH: begin
                if (fall) begin
                    state_d    = RX_IDLE;
                    evt_d.fall = 1'b1;
                    if (cls == PW_BAD) begin
                        evt_d.bad = 1'b1;
                    end else begin
                        evt_d.bit_vld = 1'b1;
                        evt_d.bit_val = (cls == PW_ONE);
                    end
                end
            end
            RX_DROP: begin
                if (fall) begin
                    state_d    = RX_IDLE;
                    evt_d.fall = 1'b1;
                end
            end
            default: state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            evt_o   <= '0;
        end else begin
            state_q <= state_d;
            evt_o   <= evt_d;
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt_o.bit_vld, evt_o.bad, evt_o.gap_err}));  // R4

    AST_BIT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        evt_o.bit_vld |-> evt_o.fall);  // R7

    AST_BAD_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        evt_o.bad |-> evt_o.fall);  // R7

    AST_BIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        evt_o.bit_vld |=> !evt_o.bit_vld);  // R10

    AST_GAP_DISCARD: assert property (@(posedge clk) disable iff (rst)
        evt_o.gap_err |=> !evt_o.bit_vld);  // R6

    AST_NO_BIT_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (lvl_q && lvl_i) |=> !evt_o.bit_vld);  // R9

endmodule

// File: rtl/pw_bit_rx.sv
module pw_bit_rx
    import pwrx_pkg::*;
#(
    parameter int unsigned MIN_ZERO_W  = 5,
    parameter int unsigned MAX_ZERO_W  = 1000,
    parameter int unsigned MIN_ONE_W   = 5000,
    parameter int unsigned MIN_GAP_W   = 1000,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned VOTE_TAPS   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic bit_vld_o,
    output logic bit_val_o,
    output logic fall_stb_o,
    output logic bad_width_o,
    output logic gap_err_o
);
    localparam int unsigned SPAN_SAT = max2(MIN_ONE_W, MIN_GAP_W);
    localparam int unsigned CNT_W    = $clog2(SPAN_SAT + 1);

    logic             lvl;
    logic             restart;
    logic [CNT_W-1:0] span;
    rx_evt_s          evt;

    pw_line_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .VOTE_TAPS   (VOTE_TAPS)
    ) i_filter (
        .clk   (clk),
        .rst   (rst),
        .raw_i (line_i),
        .lvl_o (lvl)
    );

    pw_span_counter #(
        .SAT   (SPAN_SAT),
        .CNT_W (CNT_W)
    ) i_span (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart),
        .cnt_o     (span)
    );

    pw_decide #(
        .MIN_ZERO_W (MIN_ZERO_W),
        .MAX_ZERO_W (MAX_ZERO_W),
        .MIN_ONE_W  (MIN_ONE_W),
        .MIN_GAP_W  (MIN_GAP_W),
        .CNT_W      (CNT_W)
    ) i_decide (
        .clk       (clk),
        .rst       (rst),
        .lvl_i     (lvl),
        .span_i    (span),
        .restart_o (restart),
        .evt_o     (evt)
    );

    assign bit_vld_o   = evt.bit_vld;
    assign bit_val_o   = evt.bit_val;
    assign fall_stb_o  = evt.fall;
    assign bad_width_o = evt.bad;
    assign gap_err_o   = evt.gap_err;

    AST_FALL_NEEDS_LEVEL_DROP: assert property (@(posedge clk) disable iff (rst)
        fall_stb_o |-> $past(!lvl));  // R7

endmodule

// File: tb/test_pw_bit_rx.sv
module test_pw_bit_rx;

    localparam int unsigned ZMIN = 3;
    localparam int unsigned ZMAX = 20;
    localparam int unsigned OMIN = 60;
    localparam int unsigned GMIN = 20;

    // kinds: 0 bit zero, 1 bit one, 2 bad width, 3 gap error, 4 nothing
    localparam int unsigned NVEC = 13;
    localparam int unsigned VEC [NVEC][3] = '{
        '{5,  25, 0},
        '{60, 25, 1},
        '{3,  25, 0},
        '{2,  25, 2},
        '{20, 25, 0},
        '{21, 25, 2},
        '{59, 25, 2},
        '{1,  25, 4},
        '{80, 10, 1},
        '{5,  20, 3},
        '{7,  19, 0},
        '{60, 25, 3},
        '{4,  25, 0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line = 1'b0;
    logic bit_vld, bit_val, fall_stb, bad_width, gap_err;

    int n_vld = 0, n_fall = 0, n_bad = 0, n_gap = 0, n_dbl = 0;
    int last_val = -1;
    logic prev_vld = 1'b0;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pw_bit_rx #(
        .MIN_ZERO_W (ZMIN),
        .MAX_ZERO_W (ZMAX),
        .MIN_ONE_W  (OMIN),
        .MIN_GAP_W  (GMIN)
    ) i_pw_bit_rx (
        .clk         (clk),
        .rst         (rst),
        .line_i      (line),
        .bit_vld_o   (bit_vld),
        .bit_val_o   (bit_val),
        .fall_stb_o  (fall_stb),
        .bad_width_o (bad_width),
        .gap_err_o   (gap_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (bit_vld) begin
                n_vld++;
                last_val = int'(bit_val);
            end
            if (fall_stb)  n_fall++;
            if (bad_width) n_bad++;
            if (gap_err)   n_gap++;
            if (bit_vld && prev_vld) n_dbl++;
            prev_vld = bit_vld;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic string kind_req(input int unsigned k);
        case (k)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R6";
            default: return "R5";
        endcase
    endfunction

    task automatic pulse_check(input int unsigned w, input int unsigned lo, input int unsigned k);
        int v0, f0, b0, g0;
        string rq;
        rq = kind_req(k);
        v0 = n_vld; f0 = n_fall; b0 = n_bad; g0 = n_gap;
        line = 1'b1;
        cycles(int'(w));
        line = 1'b0;
        cycles(int'(lo));
        #1;
        check(rq, $sformatf("bit strobes w=%0d", w), n_vld - v0, (k <= 1) ? 1 : 0);
        check(rq, $sformatf("bad strobes w=%0d", w), n_bad - b0, (k == 2) ? 1 : 0);
        check(rq, $sformatf("gap strobes w=%0d", w), n_gap - g0, (k == 3) ? 1 : 0);
        check((k == 4) ? "R5" : "R7", $sformatf("fall strobes w=%0d", w), n_fall - f0, (k == 4) ? 0 : 1);
        if (k <= 1)
            check(rq, $sformatf("bit value w=%0d", w), last_val, int'(k));
    endtask

    initial begin
        int v0, g0, f0, b0;
        // R1: outputs quiet during reset
        cycles(4);
        #1;
        check("R1", "strobes in reset", int'({bit_vld, fall_stb, bad_width, gap_err}), 0);
        rst = 1'b0;
        @(posedge clk); #1;
        check("R1", "strobes after release", int'({bit_vld, fall_stb, bad_width, gap_err}), 0);
        cycles(30);

        for (int i = 0; i < int'(NVEC); i++)
            pulse_check(VEC[i][0], VEC[i][1], VEC[i][2]);

        // R9: no decision while a long pulse stays high
        v0 = n_vld;
        line = 1'b1;
        cycles(120);
        #1;
        check("R9", "bit strobes while high", n_vld - v0, 0);
        cycles(30);
        line = 1'b0;
        cycles(25);
        #1;
        check("R9", "bit strobes after long pulse", n_vld - v0, 1);
        check("R3", "value of long pulse", last_val, 1);

        // R1: timer cleared by reset, early pulse counts as gap violation
        rst = 1'b1;
        cycles(3);
        rst = 1'b0;
        cycles(5);
        pulse_check(5, 25, 3);

        // R8: line stuck high through reset
        line = 1'b1;
        rst = 1'b1;
        cycles(4);
        rst = 1'b0;
        v0 = n_vld; g0 = n_gap; f0 = n_fall; b0 = n_bad;
        cycles(200);
        #1;
        check("R8", "bit strobes stuck high", n_vld - v0, 0);
        check("R8", "gap strobes stuck high", n_gap - g0, 1);
        line = 1'b0;
        cycles(30);
        #1;
        check("R8", "bit strobes after release", n_vld - v0, 0);
        check("R8", "bad strobes after release", n_bad - b0, 0);
        check("R7", "fall strobe of discarded pulse", n_fall - f0, 1);

        check("R10", "back-to-back bit strobes", n_dbl, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule